// File: doc/BRIEF.md
# Graphics-ROM Bus Port Emulator

This block stands in for a set of byte-wide graphics-ROM chips that share one linear address space on an 8-bit host bus. The host never presents an address directly. It writes an internal address register in two byte cycles, then streams data bytes through a single data port. The internal address advances by one after every data transfer. The block decodes chip select, a mode line and a read/write line. It serves reads from an attached backing store through a one-byte prefetch, so the answer is ready as soon as a cycle starts. Data writes reach the store through a one-cycle strobe that carries address and data, so the ROM space behaves like RAM.

The bus lines are asynchronous to the block clock and are brought in through a synchronizer. The data output carries a separate enable. An external tri-state buffer uses that enable, and an indicator output follows it. By default three 8K chip regions are served in full, which gives the span 0x0000 to 0x5FFF.

Top module: `grom_port_emu`

## Requirements
- R1: Every byte of the three 8K chip regions (addresses 0x0000 to 0x5FFF) is readable, including the last bytes of each region and the step from one region into the next.
- R2: With the mode line high (address register) and the read/write line low (write), two consecutive byte writes load the address register, high byte first and then low byte. The address changes only when the low byte arrives.
- R3: A cycle with chip select, mode line and read/write line all low is a data write. It raises `st_we` for exactly one clock, with `st_waddr` equal to the current address and `st_wdata` equal to the bus byte.
- R4: `bus_oe` is high only during a read cycle (read/write line high) while chip select is low. It returns low within four clocks of chip select rising, and it stays low throughout write cycles.
- R5: `busy_led` is high exactly when `bus_oe` is high.
- R6: During a read, `bus_oe` is high and `bus_dout` holds valid data no later than four clocks after chip select falls. This is far inside the 5 µs limit.
- R7: The address register increments by one after every data read and after every data write. It wraps at 16 bits.
- R8: Reads with the mode line high return the address register, high byte on the first read and low byte on the next.
- R9: At addresses of 0x6000 and above, data reads return 0xFF, data writes raise no `st_we`, and the address still increments.
- R10: A synchronous active-low reset sets the address to 0x0000 and clears the write-byte phase, so the next address write is taken as a high byte.
- R11: Any data read or data write clears both the address write phase and the address read-back phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_n | input | 1 | Chip select from the host bus, active low |
| bus_mode | input | 1 | 1 selects the address register, 0 selects data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_din | input | 8 | Byte written by the host |
| bus_dout | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | Enable for the external data bus driver |
| busy_led | output | 1 | Activity indicator, lit while driving |
| st_raddr | output | 15 | Backing store read address (current address) |
| st_rdata | input | 8 | Backing store read data |
| st_we | output | 1 | One-cycle store write strobe |
| st_waddr | output | 15 | Store write address |
| st_wdata | output | 8 | Store write data |

## Verification
The data port is tried across chip region seams (0x1FFE to 0x2000), at the top of the span (0x5FFF) and just beyond it. This tells real store bytes apart from the 0xFF fill and shows that the increment carries over region borders. Writes followed by a reload and read-back of the same address tell a real store update apart from a strobe that carries the wrong address or byte. Interleaved address-byte writes, address read-backs and data accesses, with one pattern where a lone high byte is left pending, tell phase clearing apart from phase carry-over. A reset that lands between the two address bytes shows that the write phase is cleared.

// File: rtl/grom_pkg.sv
package grom_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 16;

    typedef struct packed {
        logic              sel;     // synced chip select, previous value
        logic [ADDR_W-1:0] addr;    // auto-incrementing address
        logic [BUS_W-1:0]  hi;      // pending high address byte
        logic              wph;     // 1: next address write is low byte
        logic              rph;     // 1: next address read returns low byte
        logic [BUS_W-1:0]  pre;     // prefetched data byte
        logic              in_rd;   // read cycle in progress
        logic              rmode;   // mode of the current read
        logic              wr_en;   // store write strobe
        logic [BUS_W-1:0]  wr_data; // store write byte
    } core_t;

endpackage

// File: rtl/grom_sync.sv
module grom_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= din;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/grom_rdmux.sv
module grom_rdmux
    import grom_pkg::*;
(
    input  logic              rmode,
    input  logic              rph,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  pre,
    output logic [BUS_W-1:0]  dout
);
    always_comb begin
        if (!rmode)   dout = pre;
        else if (rph) dout = addr[7:0];
        else          dout = addr[15:8];
    end
endmodule

// File: rtl/grom_port_emu.sv
module grom_port_emu
    import grom_pkg::*;
#(
    parameter int          NUM_CHIPS   = 3,
    parameter int          CHIP_AW     = 13,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  FILL        = 8'hFF,
    localparam int         SPAN        = NUM_CHIPS << CHIP_AW,
    localparam int         AW          = $clog2(SPAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel_n,
    input  logic          bus_mode,
    input  logic          bus_rw,
    input  logic [7:0]    bus_din,
    output logic [7:0]    bus_dout,
    output logic          bus_oe,
    output logic          busy_led,
    output logic [AW-1:0] st_raddr,
    input  logic [7:0]    st_rdata,
    output logic          st_we,
    output logic [AW-1:0] st_waddr,
    output logic [7:0]    st_wdata
);
    localparam int         SW     = BUS_W + 3;
    localparam logic [16:0] SPAN17 = 17'(SPAN);
    localparam core_t CORE_RST = '{
        sel: 1'b1, addr: '0, hi: '0, wph: 1'b0, rph: 1'b0,
        pre: FILL, in_rd: 1'b0, rmode: 1'b0, wr_en: 1'b0, wr_data: '0
    };

    core_t         q, d;
    logic [AW-1:0] waddr_q, waddr_d;
    logic [SW-1:0] bus_s;
    logic          sel_s, mode_s, rw_s;
    logic [7:0]    din_s;
    logic          cyc_start, cyc_end, addr_ok;

    grom_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_sel_n, bus_mode, bus_rw, bus_din}),
        .dout (bus_s)
    );
    assign {sel_s, mode_s, rw_s, din_s} = bus_s;

    assign cyc_start = q.sel & ~sel_s;
    assign cyc_end   = ~q.sel & sel_s;
    assign addr_ok   = {1'b0, q.addr} < SPAN17;

    always_comb begin
        d         = q;
        waddr_d   = waddr_q;
        d.sel     = sel_s;
        d.wr_en   = 1'b0;
        // refresh the prefetch except while a data read is being answered
        if (!(q.in_rd && !q.rmode)) begin
            d.pre = addr_ok ? st_rdata : FILL;
        end
        if (cyc_start) begin
            if (rw_s) begin
                d.in_rd = 1'b1;
                d.rmode = mode_s;
            end else if (mode_s) begin
                if (!q.wph) begin
                    d.hi  = din_s;
                    d.wph = 1'b1;
                end else begin
                    d.addr = {q.hi, din_s};
                    d.wph  = 1'b0;
                    d.rph  = 1'b0;
                end
            end else begin
                d.wr_en   = addr_ok;
                d.wr_data = din_s;
                waddr_d   = q.addr[AW-1:0];
                d.addr    = q.addr + 16'd1;
                d.wph     = 1'b0;
                d.rph     = 1'b0;
            end
        end
        if (cyc_end && q.in_rd) begin
            d.in_rd = 1'b0;
            if (q.rmode) begin
                d.rph = ~q.rph;
            end else begin
                d.addr = q.addr + 16'd1;
                d.wph  = 1'b0;
                d.rph  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= CORE_RST;
            waddr_q <= '0;
        end else begin
            q       <= d;
            waddr_q <= waddr_d;
        end
    end

    grom_rdmux u_rdmux (
        .rmode(q.rmode),
        .rph  (q.rph),
        .addr (q.addr),
        .pre  (q.pre),
        .dout (bus_dout)
    );

    assign bus_oe   = q.in_rd;
    assign busy_led = q.in_rd;
    assign st_raddr = q.addr[AW-1:0];
    assign st_we    = q.wr_en;
    assign st_waddr = waddr_q;
    assign st_wdata = q.wr_data;

    // strobe lasts one clock per write cycle
    assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> !st_we);
    // no strobe outside the served span
    assert_wr_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> ({1'b0, {(16-AW){1'b0}}, st_waddr} < SPAN17));
    // driver released after chip select returns high
    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |=> !bus_oe);
    // read cycle start turns the driver on at once
    assert_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && rw_s) |=> bus_oe);
    // finished data read moves the address by one
    assert_incr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && q.in_rd && !q.rmode) |=> (q.addr == $past(q.addr) + 16'd1));
    // never drive and strobe together
    assert_no_drive_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> !bus_oe);
endmodule

// File: tb/sim_grom_port_emu.sv
module sim_grom_port_emu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel_n = 1'b1, bus_mode = 1'b0, bus_rw = 1'b1;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_oe, busy_led, st_we;
    logic [14:0] st_raddr, st_waddr;
    logic [7:0]  st_rdata = '0, st_wdata;

    int nchk = 0, nfail = 0;
    logic [15:0] ea = '0;
    logic        erph = 1'b0;
    logic [7:0]  ov [int];
    logic [7:0]  shadow [int];
    logic [7:0]  exp_v [$];
    string       exp_r [$];
    logic [7:0]  obs [$];
    logic [22:0] expw [$];

    always #5 clk = ~clk;

    grom_port_emu u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_mode(bus_mode),
        .bus_rw(bus_rw), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .busy_led(busy_led), .st_raddr(st_raddr), .st_rdata(st_rdata), .st_we(st_we),
        .st_waddr(st_waddr), .st_wdata(st_wdata)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + (a >> 7)) ^ 8'h5C);
    endfunction

    // backing store attached to the block
    always @(posedge clk) if (st_we) ov[int'(st_waddr)] = st_wdata;
    always @(negedge clk) st_rdata <= ov.exists(int'(st_raddr)) ? ov[int'(st_raddr)] : pat(int'(st_raddr));

    task automatic chk(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: compare produced bytes and strobes against the scoreboard
    always @(negedge clk) begin
        while (obs.size() > 0 && exp_v.size() > 0) begin
            logic [7:0] a, e;
            string r;
            a = obs.pop_front(); e = exp_v.pop_front(); r = exp_r.pop_front();
            chk(a == e, r, a, e);
        end
        if (st_we) begin
            if (expw.size() == 0) chk(0, "R9 unexpected strobe", {st_waddr, st_wdata}, 0);
            else begin
                logic [22:0] w;
                w = expw.pop_front();
                chk(w == {st_waddr, st_wdata}, "R3 strobe", {st_waddr, st_wdata}, w);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(logic m, logic [7:0] v);
        @(negedge clk);
        bus_mode = m; bus_rw = 1'b0; bus_din = v;
        idle(1);
        bus_sel_n = 1'b0;
        idle(6);
        chk(bus_oe == 1'b0, "R4 no drive on write", bus_oe, 0);
        bus_sel_n = 1'b1;
        idle(5);
    endtask

    task automatic bus_rd(logic m);
        @(negedge clk);
        bus_mode = m; bus_rw = 1'b1;
        idle(1);
        chk(bus_oe == 1'b0, "R4 idle bus", bus_oe, 0);
        bus_sel_n = 1'b0;
        idle(4);
        chk(bus_oe == 1'b1, "R6 drive in time", bus_oe, 1);
        chk(busy_led == bus_oe, "R5 indicator", busy_led, bus_oe);
        obs.push_back(bus_dout);
        bus_sel_n = 1'b1;
        idle(4);
        chk(bus_oe == 1'b0, "R4 released", bus_oe, 0);
        idle(1);
    endtask

    function automatic logic [7:0] store(logic [15:0] a);
        if (a >= 16'h6000) return 8'hFF;
        return shadow.exists(int'(a)) ? shadow[int'(a)] : pat(int'(a));
    endfunction

    task automatic load_addr(logic [15:0] a);
        bus_wr(1'b1, a[15:8]);
        bus_wr(1'b1, a[7:0]);
        ea = a; erph = 1'b0;
    endtask

    task automatic rd_data(string req);
        exp_v.push_back(store(ea)); exp_r.push_back(req);
        bus_rd(1'b0);
        ea = ea + 16'd1; erph = 1'b0;
    endtask

    task automatic wr_data(logic [7:0] v);
        if (ea < 16'h6000) begin
            expw.push_back({ea[14:0], v});
            shadow[int'(ea)] = v;
        end
        bus_wr(1'b0, v);
        ea = ea + 16'd1; erph = 1'b0;
    endtask

    task automatic rd_addr(string req);
        exp_v.push_back(erph ? ea[7:0] : ea[15:8]); exp_r.push_back(req);
        erph = ~erph;
        bus_rd(1'b1);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        ea = '0; erph = 1'b0;
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk(bus_oe == 1'b0, "R10 reset no drive", bus_oe, 0);
        chk(st_we == 1'b0, "R10 reset no strobe", st_we, 0);
        rd_data("R10 read at zero after reset");

        load_addr(16'h1FFE);
        rd_data("R2 R1 end of chip 0");
        rd_data("R1 R7 last byte chip 0");
        rd_data("R1 R7 first byte chip 1");
        rd_addr("R8 high byte");
        rd_addr("R8 low byte");

        load_addr(16'h5FFF);
        rd_data("R1 top of span");
        rd_data("R9 fill beyond span");
        wr_data(8'h77);
        rd_addr("R9 R7 high after skip");
        rd_addr("R9 R7 low after skip");

        load_addr(16'h3000);
        wr_data(8'hA5);
        wr_data(8'h5A);
        load_addr(16'h3000);
        rd_data("R3 written byte 0");
        rd_data("R3 written byte 1");
        rd_data("R7 following byte");

        load_addr(16'h0100);
        bus_wr(1'b1, 8'h12);
        rd_data("R11 data read with phase pending");
        load_addr(16'h4010);
        rd_data("R11 address after phase clear");
        rd_addr("R11 high before data");
        rd_data("R11 data between readbacks");
        rd_addr("R11 readback phase cleared");

        bus_wr(1'b1, 8'h33);
        do_reset();
        load_addr(16'h0500);
        rd_data("R10 write phase cleared by reset");

        idle(5);
        chk(exp_v.size() == 0, "R3 scoreboard drained", exp_v.size(), 0);
        chk(expw.size() == 0, "R3 all strobes seen", expw.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #2000000;
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule